// File: doc/BRIEF.md
# Frame Ping-Pong Stream Buffer

This block sits between a streaming producer and a streaming consumer that share one clock. It holds two equal storage banks. The input port writes one frame into the current fill bank while the output port reads the last completed frame out of the other bank. No word is ever moved from one bank to the other. A single select bit picks which bank is the fill bank and which is the drain bank. That bit toggles once per frame, and only when the fill side has closed its frame and the drain side has emptied its bank.

A frame closes when the input beat carries tlast, or when the fill count reaches the compile-time frame size. The length of the closed frame is recorded. The output port then delivers exactly that many beats and marks the final one with tlast. If a frame is closed while the drain bank is still being read, the input port lowers tready until the swap happens, so stored data is never overwritten. If the consumer keeps up and full frames arrive back to back, the swap falls on the same edge as both final beats and neither port ever waits.

Top module: `pp_frame_buf`

## Requirements
- R1: After reset, s_tready is 1 and m_tvalid is 0, and the output stays idle until a frame has been closed.
- R2: Output data words come out in the same order as they were accepted on the input, frame by frame, with no word lost, repeated or overwritten.
- R3: A frame that reaches FRAME_LEN accepted beats without an input tlast is closed at that size, and its FRAME_LEN-th output beat carries m_tlast = 1. No output frame is longer than FRAME_LEN beats.
- R4: A frame closed early by an input beat with s_tlast = 1 is emitted with the same number of beats, and m_tlast = 1 is set only on its last beat.
- R5: While a closed frame waits for the drain bank to empty, s_tready is 0.
- R6: When a frame closes on a cycle in which the drain bank is free (idle, or its last beat is being accepted), m_tvalid is 1 in the next cycle.
- R7: While m_tvalid is 1 and m_tready is 0, m_tvalid, m_tdata and m_tlast hold their values into the next cycle.
- R8: With the consumer always ready and full-size frames arriving back to back, s_tready never drops.
- R9: A one-beat frame (s_tlast on its first beat) produces a single output beat with m_tlast = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted when high with s_tvalid |
| s_tdata | input | DATA_W | Input data word |
| s_tlast | input | 1 | Closes the current input frame |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Consumer accepts output beat |
| m_tdata | output | DATA_W | Output data word |
| m_tlast | output | 1 | Final beat of the output frame |

## Verification
The hardest state to reach is a fill frame that is closed and blocked while the drain bank is still full. This needs the consumer to stall for longer than a whole frame while the producer keeps sending. The bench holds m_tready low, sends one frame so that it swaps into the drain bank, then sends a second short frame. It then checks at the port that s_tready stays low. After releasing the consumer, it checks that both frames come out intact. A separate phase keeps the consumer ready and sends full frames back to back. This reaches the opposite corner, where the fill close and the drain finish land on the same edge, and the bench confirms the producer never sees a stall.

// File: rtl/pp_frame_pkg.sv
package pp_frame_pkg;

  typedef enum logic {
    BANK_LO = 1'b0,
    BANK_HI = 1'b1
  } bank_id_e;

  localparam int unsigned NUM_BANKS = 2;

  function automatic bank_id_e other_bank(input bank_id_e b);
    return (b == BANK_LO) ? BANK_HI : BANK_LO;
  endfunction

endpackage

// File: rtl/pp_bank_store.sv
module pp_bank_store
  import pp_frame_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  bank_id_e          wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  bank_id_e          rd_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] rd_word [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    logic              bank_we;

    always_comb begin
      bank_we = wr_en && (wr_bank == bank_id_e'(b));
    end

    always_ff @(posedge clk) begin
      if (bank_we) begin
        mem[wr_addr] <= wr_data;
      end
    end

    always_comb begin
      rd_word[b] = mem[rd_addr];
    end
  end

  always_comb begin
    rd_data = rd_word[rd_bank];
  end

endmodule

// File: rtl/pp_fill_ctrl.sv
module pp_fill_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  input  logic              swap,
  output logic              s_tready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              pending,
  output logic [CNT_W-1:0]  frame_len
);

  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic              held_q, held_d;
  logic [CNT_W-1:0]  len_q, len_d;
  logic              beat;
  logic              at_end;
  logic              close_now;
  logic [CNT_W-1:0]  cnt_plus;

  always_comb begin
    s_tready  = !held_q;
    beat      = s_tvalid && s_tready;
    at_end    = (cnt_q == ADDR_W'(DEPTH - 1));
    close_now = beat && (s_tlast || at_end);
    cnt_plus  = CNT_W'(cnt_q) + CNT_W'(1);
    wr_en     = beat;
    wr_addr   = cnt_q;
    pending   = held_q || close_now;
    frame_len = close_now ? cnt_plus : len_q;
  end

  always_comb begin
    cnt_d  = cnt_q;
    held_d = held_q;
    len_d  = len_q;
    if (close_now) begin
      cnt_d = '0;
      len_d = cnt_plus;
    end else if (beat) begin
      cnt_d = cnt_q + ADDR_W'(1);
    end
    if (swap) begin
      held_d = 1'b0;
    end else if (close_now) begin
      held_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
      len_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      held_q <= held_d;
      len_q  <= len_d;
    end
  end

endmodule

// File: rtl/pp_drain_ctrl.sv
module pp_drain_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap,
  input  logic [CNT_W-1:0]  new_len,
  input  logic              m_tready,
  output logic              m_tvalid,
  output logic              m_tlast,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              drain_free
);

  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0]  len_q, len_d;
  logic              on_last;
  logic              take;

  always_comb begin
    on_last    = busy_q && ((CNT_W'(cnt_q) + CNT_W'(1)) == len_q);
    take       = busy_q && m_tready;
    m_tvalid   = busy_q;
    m_tlast    = on_last;
    rd_addr    = cnt_q;
    drain_free = !busy_q || (take && on_last);
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    if (swap) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      len_d  = new_len;
    end else if (take) begin
      if (on_last) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + ADDR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
    end
  end

endmodule

// File: rtl/pp_swap_ctrl.sv
module pp_swap_ctrl
  import pp_frame_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pending,
  input  logic     drain_free,
  output logic     swap,
  output bank_id_e wr_bank,
  output bank_id_e rd_bank
);

  bank_id_e sel_q, sel_d;

  always_comb begin
    swap    = pending && drain_free;
    sel_d   = swap ? other_bank(sel_q) : sel_q;
    wr_bank = sel_q;
    rd_bank = other_bank(sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= BANK_LO;
    end else begin
      sel_q <= sel_d;
    end
  end

endmodule

// File: rtl/pp_frame_buf.sv
module pp_frame_buf
  import pp_frame_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned FRAME_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tlast,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tlast
);

  localparam int unsigned ADDR_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam int unsigned CNT_W  = $clog2(FRAME_LEN + 1);

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic              pending;
  logic [CNT_W-1:0]  frame_len;
  logic              drain_free;
  logic              swap;
  bank_id_e          wr_bank;
  bank_id_e          rd_bank;

  pp_fill_ctrl #(.DEPTH(FRAME_LEN)) u_fill (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_tvalid  (s_tvalid),
    .s_tlast   (s_tlast),
    .swap      (swap),
    .s_tready  (s_tready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .pending   (pending),
    .frame_len (frame_len)
  );

  pp_drain_ctrl #(.DEPTH(FRAME_LEN)) u_drain (
    .clk        (clk),
    .rst_n      (rst_n),
    .swap       (swap),
    .new_len    (frame_len),
    .m_tready   (m_tready),
    .m_tvalid   (m_tvalid),
    .m_tlast    (m_tlast),
    .rd_addr    (rd_addr),
    .drain_free (drain_free)
  );

  pp_swap_ctrl u_swap (
    .clk        (clk),
    .rst_n      (rst_n),
    .pending    (pending),
    .drain_free (drain_free),
    .swap       (swap),
    .wr_bank    (wr_bank),
    .rd_bank    (rd_bank)
  );

  pp_bank_store #(.DATA_W(DATA_W), .DEPTH(FRAME_LEN)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_bank (wr_bank),
    .wr_addr (wr_addr),
    .wr_data (s_tdata),
    .rd_bank (rd_bank),
    .rd_addr (rd_addr),
    .rd_data (m_tdata)
  );

endmodule

// File: rtl/pp_frame_buf_chk.sv
module pp_frame_buf_chk #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned FRAME_LEN = 8,
  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_tvalid,
  input logic              s_tready,
  input logic              s_tlast,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic [DATA_W-1:0] m_tdata,
  input logic              m_tlast
);

  logic [CNT_W-1:0] out_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cnt <= '0;
    end else if (m_tvalid && m_tready) begin
      out_cnt <= m_tlast ? '0 : out_cnt + CNT_W'(1);
    end
  end

  // R3: the FRAME_LEN-th output beat must close the frame
  p_frame_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && (out_cnt == CNT_W'(FRAME_LEN - 1))) |-> m_tlast);

  // R5: closed frame with a busy drain bank blocks the input
  p_fill_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready && s_tlast && m_tvalid && !(m_tready && m_tlast))
      |=> !s_tready);

  // R6: closed frame with a free drain bank is presented next cycle
  p_swap_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready && s_tlast && (!m_tvalid || (m_tready && m_tlast)))
      |=> m_tvalid);

  // R7: stalled output holds steady
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready)
      |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

endmodule

bind pp_frame_buf pp_frame_buf_chk #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_tvalid (s_tvalid),
  .s_tready (s_tready),
  .s_tlast  (s_tlast),
  .m_tvalid (m_tvalid),
  .m_tready (m_tready),
  .m_tdata  (m_tdata),
  .m_tlast  (m_tlast)
);

// File: tb/pp_frame_buf_bench.sv
module pp_frame_buf_bench;

  localparam int DW = 16;
  localparam int FL = 8;

  logic          clk;
  logic          rst_n;
  logic          s_tvalid;
  logic          s_tready;
  logic [DW-1:0] s_tdata;
  logic          s_tlast;
  logic          m_tvalid;
  logic          m_tready;
  logic [DW-1:0] m_tdata;
  logic          m_tlast;

  pp_frame_buf #(.DATA_W(DW), .FRAME_LEN(FL)) u_pp_frame_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .s_tdata  (s_tdata),
    .s_tlast  (s_tlast),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tdata  (m_tdata),
    .m_tlast  (m_tlast)
  );

  typedef struct {
    logic [DW-1:0] data;
    logic          last;
    logic          full;
  } exp_t;

  exp_t          sb_q[$];
  int            errors = 0;
  int            checks = 0;
  int            stalls = 0;
  int            rdy_mode = 0;
  logic [DW-1:0] seq = 16'h1000;
  logic [7:0]    lfsr = 8'h5A;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic push_beat(input logic [DW-1:0] d, input logic l);
    @(negedge clk);
    s_tvalid = 1'b1;
    s_tdata  = d;
    s_tlast  = l;
    #2;
    while (!s_tready) begin
      stalls++;
      @(negedge clk);
      #2;
    end
  endtask

  task automatic send_frame(input int len, input logic use_last);
    for (int i = 0; i < len; i++) begin
      exp_t e;
      e.data = seq;
      e.last = (i == len - 1);
      e.full = !use_last;
      sb_q.push_back(e);
      push_beat(seq, use_last && (i == len - 1));
      seq = seq + 16'd1;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  task automatic wait_empty();
    while (sb_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    logic          prev_stall;
    logic [DW-1:0] held_d;
    logic          held_l;
    prev_stall = 1'b0;
    held_d = '0;
    held_l = 1'b0;
    m_tready = 1'b0;
    forever begin
      @(negedge clk);
      case (rdy_mode)
        0: m_tready = 1'b1;
        1: m_tready = 1'b0;
        default: m_tready = lfsr[0];
      endcase
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      #1;
      if (rst_n) begin
        if (prev_stall) begin
          // R7: a stalled beat must not change
          chk(m_tvalid && (m_tdata == held_d) && (m_tlast == held_l),
              "R7 stalled beat changed", int'(m_tdata), int'(held_d));
        end
        prev_stall = m_tvalid && !m_tready;
        held_d = m_tdata;
        held_l = m_tlast;
        if (m_tvalid && m_tready) begin
          if (sb_q.size() == 0) begin
            chk(1'b0, "R2 unexpected output beat", int'(m_tdata), -1);
          end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(m_tdata == e.data, "R2 data order", int'(m_tdata), int'(e.data));
            if (e.full)
              chk(m_tlast == e.last, "R3 full-size tlast", int'(m_tlast), int'(e.last));
            else
              chk(m_tlast == e.last, "R4 early-close tlast", int'(m_tlast), int'(e.last));
          end
        end
      end else begin
        prev_stall = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", sb_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    s_tvalid = 1'b0;
    s_tdata  = '0;
    s_tlast  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: idle after reset
    chk(s_tready == 1'b1, "R1 s_tready after reset", int'(s_tready), 1);
    chk(m_tvalid == 1'b0, "R1 m_tvalid after reset", int'(m_tvalid), 0);
    repeat (3) @(negedge clk);
    #2;
    chk(m_tvalid == 1'b0, "R1 output idle with no frame", int'(m_tvalid), 0);

    // R2 and R4: a full frame then an early-closed one
    send_frame(FL, 1'b1);
    send_frame(3, 1'b1);
    idle();
    wait_empty();

    // R9 and R6: single-beat frame into a free drain bank
    send_frame(1, 1'b1);
    idle();
    #2;
    chk(m_tvalid == 1'b1, "R6 m_tvalid after close", int'(m_tvalid), 1);
    chk(m_tlast == 1'b1, "R9 single beat tlast", int'(m_tlast), 1);
    wait_empty();

    // R3: frames closed by the size limit, no input tlast
    send_frame(FL, 1'b0);
    send_frame(FL, 1'b0);
    send_frame(2, 1'b1);
    idle();
    wait_empty();

    // R5: second frame blocked while the drain bank is held
    rdy_mode = 1;
    send_frame(FL, 1'b1);
    send_frame(5, 1'b1);
    idle();
    #2;
    chk(s_tready == 1'b0, "R5 s_tready while blocked", int'(s_tready), 0);
    repeat (5) @(negedge clk);
    #2;
    chk(s_tready == 1'b0, "R5 s_tready still blocked", int'(s_tready), 0);
    chk(m_tvalid == 1'b1, "R5 drain frame still offered", int'(m_tvalid), 1);
    rdy_mode = 0;
    wait_empty();

    // R8: back-to-back full frames with a ready consumer
    stalls = 0;
    for (int f = 0; f < 4; f++) send_frame(FL, 1'b1);
    idle();
    chk(stalls == 0, "R8 producer stalls", stalls, 0);
    wait_empty();

    // mixed lengths with a random consumer
    rdy_mode = 2;
    for (int f = 0; f < 30; f++) begin
      int len;
      len = 1 + ((f * 5) % FL);
      send_frame(len, !((len == FL) && (f % 2 == 0)));
    end
    idle();
    wait_empty();
    rdy_mode = 0;
    chk(sb_q.size() == 0, "R2 all beats delivered", sb_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule